// File: doc/BRIEF.md
# Register Scoreboard with Shared Writeback Queue

This block decides, one instruction at a time, whether an in-order pipeline may let an instruction into execute. It does this without a global stall signal. It keeps one busy flag per architectural register. An instruction is admitted only when none of the registers it reads is busy and its own destination is free. Admission marks the destination busy. The flag drops again when a result for that register is written back.

Results come back in two ways. Fixed-latency units report through dedicated writeback ports, and each of those ports only clears a busy flag. Variable-latency units, such as loads and long floating-point operations, hand their result with its data to the block. Those results wait in a small in-order queue. The queue drains one entry per cycle onto a single shared write port, which feeds the register storage and clears the busy flag. While the queue is close to full, new variable-latency instructions are refused. Other instructions still flow.

Top module: `reg_scoreboard`

## Requirements
- R1: `iss_grant` is high only while `iss_valid` is high and neither source register is busy. Register 0 never blocks as a source.
- R2: On the clock edge that grants an instruction with `iss_has_dst` high, its destination becomes busy, unless that destination is register 0. Register 0 is never busy.
- R3: An instruction whose destination is busy is not granted.
- R4: A pulse on fixed writeback port k (`fix_valid[k]`, register id in `fix_id[k*AW +: AW]`) clears that busy flag. The clear is seen by `iss_grant` in the cycle after the pulse, not in the same cycle.
- R5: Each async result is stored in the queue on the edge it arrives. It appears on `wb_valid`/`wb_id`/`wb_data` from the next cycle on. Exactly one entry leaves per cycle. Results are delivered in arrival order, and within one cycle the lower port index goes first.
- R6: A shared-port write clears the busy flag of `wb_id`. A dependent instruction can be granted in the cycle after the write is shown.
- R7: While queue occupancy exceeds QDEPTH−NASYNC (3 or more with the defaults), a request with `iss_async` high is refused. A request with `iss_async` low is not affected.
- R8: After reset, no register is busy, the queue is empty and `wb_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request present |
| iss_src_a | input | AW | First source register id |
| iss_src_b | input | AW | Second source register id |
| iss_dst | input | AW | Destination register id |
| iss_has_dst | input | 1 | Instruction writes a register |
| iss_async | input | 1 | Instruction completes with variable latency |
| iss_grant | output | 1 | Instruction may enter execute this cycle |
| fix_valid | input | NFIX | Fixed-latency writeback strobes |
| fix_id | input | NFIX*AW | Fixed-latency writeback register ids |
| ar_valid | input | NASYNC | Async result strobes |
| ar_id | input | NASYNC*AW | Async result register ids |
| ar_data | input | NASYNC*DW | Async result data |
| wb_valid | output | 1 | Shared write port active |
| wb_id | output | AW | Shared write port register id |
| wb_data | output | DW | Shared write port data |

## Verification
The refusal of async work is the hardest case to reach from the ports. The queue loses one entry every cycle, so occupancy only builds up when two results arrive together in back-to-back cycles. The bench first grants four async instructions. It then delivers their results in pairs on consecutive cycles, which brings occupancy to three. In that same cycle it tries an async request and then a plain request. While the queue drains, it also checks the delivery order cycle by cycle.

// File: rtl/reg_scoreboard.sv
module reg_scoreboard #(
  parameter int NREG   = 32,
  parameter int DW     = 32,
  parameter int NFIX   = 2,
  parameter int NASYNC = 2,
  parameter int QDEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_valid,
  input  logic [$clog2(NREG)-1:0]  iss_src_a,
  input  logic [$clog2(NREG)-1:0]  iss_src_b,
  input  logic [$clog2(NREG)-1:0]  iss_dst,
  input  logic                     iss_has_dst,
  input  logic                     iss_async,
  output logic                     iss_grant,
  input  logic [NFIX-1:0]          fix_valid,
  input  logic [NFIX*$clog2(NREG)-1:0] fix_id,
  input  logic [NASYNC-1:0]        ar_valid,
  input  logic [NASYNC*$clog2(NREG)-1:0] ar_id,
  input  logic [NASYNC*DW-1:0]     ar_data,
  output logic                     wb_valid,
  output logic [$clog2(NREG)-1:0]  wb_id,
  output logic [DW-1:0]            wb_data
);
  localparam int AW  = $clog2(NREG);
  localparam int QAW = $clog2(QDEPTH);
  localparam int CW  = QAW + 1;

  logic [NREG-1:0] busy, busy_next;
  logic [AW-1:0]   q_id   [QDEPTH];
  logic [DW-1:0]   q_data [QDEPTH];
  logic [QAW-1:0]  rptr, wptr;
  logic [CW-1:0]   count, npush;
  logic            src_a_busy, src_b_busy, dst_busy, async_full;

  function automatic logic [CW-1:0] ones_below(input logic [NASYNC-1:0] v, input int k);
    ones_below = '0;
    for (int i = 0; i < NASYNC; i++)
      if (i < k && v[i]) ones_below = ones_below + CW'(1);
  endfunction

  assign npush      = ones_below(ar_valid, NASYNC);
  assign src_a_busy = (iss_src_a != '0) && busy[iss_src_a];
  assign src_b_busy = (iss_src_b != '0) && busy[iss_src_b];
  assign dst_busy   = iss_has_dst && (iss_dst != '0) && busy[iss_dst];
  assign async_full = count > CW'(QDEPTH - NASYNC);
  assign iss_grant  = iss_valid && !src_a_busy && !src_b_busy && !dst_busy
                      && !(iss_async && async_full);

  assign wb_valid = count != '0;
  assign wb_id    = q_id[rptr];
  assign wb_data  = q_data[rptr];

  always_comb begin
    busy_next = busy;
    for (int k = 0; k < NFIX; k++)
      if (fix_valid[k]) busy_next[fix_id[k*AW +: AW]] = 1'b0;
    if (wb_valid) busy_next[wb_id] = 1'b0;
    if (iss_grant && iss_has_dst) busy_next[iss_dst] = 1'b1;
    busy_next[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= '0;
    else        busy <= busy_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else begin
      if (wb_valid) rptr <= rptr + QAW'(1);
      wptr  <= wptr + QAW'(npush);
      count <= count + npush - CW'(wb_valid);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NASYNC; k++)
      if (ar_valid[k]) begin
        q_id[wptr + QAW'(ones_below(ar_valid, k))]   <= ar_id[k*AW +: AW];
        q_data[wptr + QAW'(ones_below(ar_valid, k))] <= ar_data[k*DW +: DW];
      end
  end

  AST_DST_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_grant && iss_has_dst && iss_dst != '0) |=> busy[$past(iss_dst)]); // R2

  AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(iss_grant && iss_has_dst && iss_dst == wb_id)) |=> !busy[$past(wb_id)]); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|ar_valid) |-> (int'(count) + int'(npush) - int'(wb_valid) <= QDEPTH)); // R5

  AST_GRANT_SRC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    iss_grant |-> !(busy[iss_src_a] && iss_src_a != '0) && !(busy[iss_src_b] && iss_src_b != '0)); // R1

  for (genvar k = 0; k < NFIX; k++) begin : g_fix_chk
    AST_FIX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (fix_valid[k] && !(iss_grant && iss_has_dst && iss_dst == fix_id[k*AW +: AW]))
      |=> !busy[$past(fix_id[k*AW +: AW])]); // R4
  end
endmodule

// File: tb/reg_scoreboard_test.sv
`timescale 1ns/1ps
module reg_scoreboard_test;
  localparam int AW = 5, DW = 32;
  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_has_dst = 0, iss_async = 0;
  logic [AW-1:0] iss_src_a = 0, iss_src_b = 0, iss_dst = 0;
  logic iss_grant;
  logic [1:0] fix_valid = 0;
  logic [2*AW-1:0] fix_id = 0;
  logic [1:0] ar_valid = 0;
  logic [2*AW-1:0] ar_id = 0;
  logic [2*DW-1:0] ar_data = 0;
  logic wb_valid;
  logic [AW-1:0] wb_id;
  logic [DW-1:0] wb_data;
  int checks = 0, errors = 0;
  bit done = 0;

  reg_scoreboard uut (.clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_src_a(iss_src_a),
    .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_has_dst(iss_has_dst), .iss_async(iss_async),
    .iss_grant(iss_grant), .fix_valid(fix_valid), .fix_id(fix_id), .ar_valid(ar_valid),
    .ar_id(ar_id), .ar_data(ar_data), .wb_valid(wb_valid), .wb_id(wb_id), .wb_data(wb_data));

  always #10 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_iss(input int a, input int b, input int d, input bit hd, input bit as);
    iss_valid = 1; iss_src_a = AW'(a); iss_src_b = AW'(b); iss_dst = AW'(d);
    iss_has_dst = hd; iss_async = as;
  endtask

  task automatic try_issue(input int a, input int b, input int d, input bit hd, input bit as,
                           input string req, input bit exp);
    @(negedge clk);
    set_iss(a, b, d, hd, as);
    #1 chk(req, iss_grant, exp);
    @(posedge clk); #1 iss_valid = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R8 wb_valid after reset", wb_valid, 0);
    try_issue(1, 2, 5, 1, 0, "R8 all free after reset", 1);
  endtask

  task automatic t_sources_and_dst;
    try_issue(5, 0, 6, 1, 0, "R1 busy src_a blocks", 0);
    try_issue(0, 5, 6, 1, 0, "R1 busy src_b blocks", 0);
    try_issue(0, 0, 0, 1, 0, "R2 dst zero granted", 1);
    try_issue(0, 0, 7, 1, 0, "R2 reg0 stays free as source", 1);
    try_issue(7, 0, 9, 1, 0, "R2 dst marked busy", 0);
    try_issue(0, 0, 5, 1, 0, "R3 busy dst blocks", 0);
    try_issue(0, 0, 5, 0, 0, "R3 no-dst instruction ignores dst", 1);
  endtask

  task automatic t_fixed;
    @(negedge clk);
    fix_valid = 2'b10; fix_id = {AW'(5), AW'(0)};
    set_iss(5, 0, 8, 1, 0);
    #1 chk("R4 clear not visible same cycle", iss_grant, 0);
    @(posedge clk); #1 fix_valid = 0; iss_valid = 0;
    try_issue(5, 0, 8, 1, 0, "R4 clear visible next cycle", 1);
  endtask

  task automatic t_async_pair;
    try_issue(0, 0, 9, 1, 1, "R5 async issue dst 9", 1);
    try_issue(0, 0, 10, 1, 1, "R5 async issue dst 10", 1);
    @(negedge clk);
    ar_valid = 2'b11; ar_id = {AW'(9), AW'(10)}; ar_data = {32'hBBBB_0009, 32'hAAAA_0010};
    #1 chk("R5 not shown on arrival cycle", wb_valid, 0);
    @(posedge clk); #1 ar_valid = 0;
    @(negedge clk);
    chk("R5 wb_valid next cycle", wb_valid, 1);
    chk("R5 lower port first id", wb_id, 10);
    chk("R5 lower port first data", wb_data, 32'hAAAA_0010);
    set_iss(9, 0, 0, 0, 0);
    #1 chk("R6 queued reg 9 still busy", iss_grant, 0);
    @(posedge clk); #1 iss_valid = 0;
    @(negedge clk);
    chk("R5 second entry id", wb_id, 9);
    chk("R5 second entry data", wb_data, 32'hBBBB_0009);
    set_iss(10, 0, 0, 0, 0);
    #1 chk("R6 reg 10 free after write", iss_grant, 1);
    @(posedge clk); #1 iss_valid = 0;
    @(negedge clk);
    chk("R5 queue empty", wb_valid, 0);
    set_iss(9, 0, 0, 0, 0);
    #1 chk("R6 reg 9 free after write", iss_grant, 1);
    @(posedge clk); #1 iss_valid = 0;
  endtask

  task automatic t_gate;
    for (int r = 11; r <= 14; r++) try_issue(0, 0, r, 1, 1, "R7 async issue with room", 1);
    @(negedge clk);
    ar_valid = 2'b11; ar_id = {AW'(12), AW'(11)}; ar_data = {32'd12, 32'd11};
    @(negedge clk);
    chk("R5 order 11", wb_id, 11);
    ar_valid = 2'b11; ar_id = {AW'(14), AW'(13)}; ar_data = {32'd14, 32'd13};
    @(posedge clk); #1 ar_valid = 0;
    @(negedge clk);
    chk("R5 order 12", wb_id, 12);
    set_iss(0, 0, 15, 1, 1);
    #1 chk("R7 async refused at occupancy 3", iss_grant, 0);
    iss_async = 0;
    #1 chk("R7 sync still granted at occupancy 3", iss_grant, 1);
    @(posedge clk); #1 iss_valid = 0;
    @(negedge clk);
    chk("R5 order 13", wb_id, 13);
    set_iss(0, 0, 16, 1, 1);
    #1 chk("R7 async allowed at occupancy 2", iss_grant, 1);
    @(posedge clk); #1 iss_valid = 0;
    @(negedge clk);
    chk("R5 order 14", wb_id, 14);
    chk("R5 order 14 data", wb_data, 14);
    @(negedge clk);
    chk("R5 drained", wb_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_sources_and_dst;
    t_fixed;
    t_async_pair;
    t_gate;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule